// File: doc/BRIEF.md
# Eight-Bit Reload Timer with Toggle and PWM Output

This block is an 8-bit up-counter that advances once per tick of a selectable prescaler tap. The prescaler divides the peripheral clock. The counter either wraps from 0xFF to 0x00 or reloads from a write register when it overflows. Every overflow raises a sticky request flag. A single mask bit gates that flag onto the interrupt line.

The timer output pin has four states: held low, toggling on each overflow, or pulse-width modulated with a period of either 256 ticks or a shortened 64 ticks. The PWM high time follows a threshold taken from the write register. The block samples that threshold only at an overflow or at start, so a new value never disturbs the period already running.

Software reaches the block over a 4-bit data bus. The 8-bit write register is written as two digits. The 8-bit count is read as two digits: a read of the upper digit captures the lower digit at the same moment, so the pair always comes from one count value.

Top module: `reload_pwm_timer`

## Requirements
- R1: After reset the counter, write register, both mode registers and the run bit are zero, the request flag is clear, and `tmr_out` and `irq` are low.
- R2: Clock-mode register (address 0) bits [2:0] select the prescaler tap. Codes 0..7 give divide by 2, 4, 8, 32, 128, 512, 1024 and 2048. While running, the counter advances once per that many clocks. Clock-mode bit 3 set selects reload operation.
- R3: Writing the control register (address 4) with bit 0 set while stopped starts the timer. Start loads the counter from the write register (with zero in a PWM style), restarts the prescaler and clears the toggle state. Writing bit 0 clear stops the timer, and the count then holds.
- R4: In free-running operation, the tick after 0xFF yields 0x00 and is an overflow.
- R5: In reload operation outside PWM styles, the tick after 0xFF loads the write register and is an overflow.
- R6: A write to address 2 sets the lower digit of the write register, and a write to address 3 sets the upper digit. Neither write changes the counter.
- R7: A read of address 3 returns count bits [7:4] and captures count bits [3:0]. A read of address 2 returns the last captured lower digit, even after the counter has moved on.
- R8: Each overflow sets the request flag, which stays set until a control write with bit 1 set clears it; an overflow wins over a clear in the same cycle. Control reads return run in bit 0 and the flag in bit 1. `irq` is the flag ANDed with output-mode bit 3.
- R9: Output-mode register (address 1) bits [1:0]: 00 and 11 hold the pin low, 01 selects toggle, 10 selects PWM. In toggle style the pin inverts on every overflow.
- R10: In PWM style with output-mode bit 2 clear, the counter counts 0..255 and wraps to 0 whatever the reload bit says. The pin is high while the count is below the threshold.
- R11: In PWM style with output-mode bit 2 set, the counter counts 0..63, and each wrap is an overflow. The pin is high while the count is below threshold bits [7:2].
- R12: The PWM threshold takes the write-register value only at start and at an overflow. A write-register change in mid-period leaves the current waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (a read of address 3 captures the lower digit) |
| bus_wdata | input | 4 | Write data digit |
| bus_rdata | output | 4 | Read data digit for the selected register |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Masked overflow request |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 64-tick short PWM period, and an 11-bit prescaler reaching divide by 2048. With the divide-by-2 tap, a full 256-tick period fits in about 512 clocks. This keeps several overflows, reload sequences and PWM periods, with a threshold change in mid-period, within a short run. The divide-by-8 and divide-by-512 taps are measured by exact tick counts over a timed run window.

// File: rtl/rpt_pkg.sv
// Package: shared types, register addresses and prescaler tap table for the
// reload PWM timer. Assumes an 8-bit counter reached through 4-bit digits.
package rpt_pkg;

    typedef enum logic [1:0] {
        OUT_LOW    = 2'b00,
        OUT_TOGGLE = 2'b01,
        OUT_PWM    = 2'b10,
        OUT_IDLE   = 2'b11
    } out_style_e;

    localparam logic [2:0] ADDR_CLKMODE = 3'd0;
    localparam logic [2:0] ADDR_OUTMODE = 3'd1;
    localparam logic [2:0] ADDR_DATA_LO = 3'd2;
    localparam logic [2:0] ADDR_DATA_HI = 3'd3;
    localparam logic [2:0] ADDR_CTRL    = 3'd4;

    // log2 of the division ratio for each tap select code
    function automatic int tap_log2(input int sel);
        case (sel)
            0:       return 1;
            1:       return 2;
            2:       return 3;
            3:       return 5;
            4:       return 7;
            5:       return 9;
            6:       return 10;
            default: return 11;
        endcase
    endfunction

endpackage

// File: rtl/rpt_prescaler.sv
// Prescaler: free counter cleared while the timer is stopped; emits a one-cycle
// tick each time the selected low-order bits are all ones. Assumes every tap
// exponent fits in PRESC_W bits (larger ones are clipped).
module rpt_prescaler #(
    parameter int PRESC_W = 11,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    import rpt_pkg::*;

    localparam int NUM_TAPS = 2 ** SEL_W;

    logic [PRESC_W-1:0]  presc_q;
    logic [NUM_TAPS-1:0] tap_hit;

    // Divider count: runs only while the timer runs, restarts from zero on start
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
            localparam int EXP = (tap_log2(i) > PRESC_W) ? PRESC_W : tap_log2(i);
            // Tap i fires on the last count of each 2**EXP window
            assign tap_hit[i] = &presc_q[EXP-1:0];
        end
    endgenerate

    // Tick only while running
    always_comb begin
        tick = run && tap_hit[sel];
    end

endmodule

// File: rtl/rpt_counter.sv
// Counter core: 8-bit up-counter with free-running, reload and PWM wrap rules,
// overflow detection and the PWM threshold register. Assumes start and tick
// never coincide (start happens only while stopped).
module rpt_counter #(
    parameter int CNT_W      = 8,
    parameter int SHORT_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             reload_en,
    input  logic             pwm_en,
    input  logic             short_en,
    input  logic [CNT_W-1:0] wreg,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] thr,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] FULL_TOP  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] SHORT_TOP = CNT_W'((2 ** SHORT_LOG2) - 1);

    logic [CNT_W-1:0] top_val;
    logic [CNT_W-1:0] wrap_val;

    // Last count before wrap, and the value loaded at the wrap
    always_comb begin
        top_val  = (pwm_en && short_en) ? SHORT_TOP : FULL_TOP;
        wrap_val = (reload_en && !pwm_en) ? wreg : '0;
        ovf      = tick && (cnt == top_val);
    end

    // Count register: load on start, advance or wrap on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= pwm_en ? '0 : wreg;
        end else if (ovf) begin
            cnt <= wrap_val;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Threshold register: sampled from the write register only at start or overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= '0;
        end else if (start || ovf) begin
            thr <= wreg;
        end
    end

endmodule

// File: rtl/rpt_outgen.sv
// Output generator: toggle flop and PWM comparator; selects the pin value from
// the output style. Assumes cnt stays below the short period in short PWM.
module rpt_outgen #(
    parameter int CNT_W      = 8,
    parameter int SHORT_LOG2 = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  rpt_pkg::out_style_e style,
    input  logic                short_en,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [CNT_W-1:0]    thr,
    input  logic                ovf,
    input  logic                start,
    output logic                pin
);
    import rpt_pkg::*;

    localparam int SHIFT = CNT_W - SHORT_LOG2;

    logic             tog_q;
    logic [CNT_W-1:0] thr_eff;
    logic             pwm_hi;

    // Toggle state: cleared on start, inverted on each overflow in toggle style
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            tog_q <= 1'b0;
        end else if (ovf && style == OUT_TOGGLE) begin
            tog_q <= ~tog_q;
        end
    end

    // PWM compare against the full or scaled-down threshold
    always_comb begin
        thr_eff = short_en ? (thr >> SHIFT) : thr;
        pwm_hi  = cnt < thr_eff;
    end

    // Pin select by output style
    always_comb begin
        case (style)
            OUT_TOGGLE: pin = tog_q;
            OUT_PWM:    pin = pwm_hi;
            default:    pin = 1'b0;
        endcase
    end

endmodule

// File: rtl/rpt_regs.sv
// Register file: mode registers, two-digit write register, run bit, request
// flag, lower-digit capture and read multiplexer. Assumes one-cycle strobes.
module rpt_regs #(
    parameter int CNT_W = 8,
    parameter int DIG_W = 4,
    parameter int SEL_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DIG_W-1:0]    bus_wdata,
    output logic [DIG_W-1:0]    bus_rdata,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                ovf,
    output logic [SEL_W-1:0]    clk_sel,
    output logic                reload_en,
    output rpt_pkg::out_style_e style,
    output logic                short_en,
    output logic                irq_mask,
    output logic [CNT_W-1:0]    wreg,
    output logic                run,
    output logic                start,
    output logic                flag
);
    import rpt_pkg::*;

    logic [DIG_W-1:0] clkmode_q;
    logic [DIG_W-1:0] outmode_q;
    logic [DIG_W-1:0] lo_latch_q;
    logic             wr_ctrl;
    logic             flag_clr;

    // Decode of control writes
    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
        start    = wr_ctrl && bus_wdata[0] && !run;
        flag_clr = wr_ctrl && bus_wdata[1];
    end

    // Mode registers and write-register digits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clkmode_q <= '0;
            outmode_q <= '0;
            wreg      <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_CLKMODE: clkmode_q <= bus_wdata;
                ADDR_OUTMODE: outmode_q <= bus_wdata;
                ADDR_DATA_LO: wreg[DIG_W-1:0] <= bus_wdata;
                ADDR_DATA_HI: wreg[CNT_W-1:DIG_W] <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Run bit follows control writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (wr_ctrl) begin
            run <= bus_wdata[0];
        end
    end

    // Sticky request flag, overflow has priority over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (ovf) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    // Lower-digit capture on an upper-digit read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_latch_q <= '0;
        end else if (bus_rd && bus_addr == ADDR_DATA_HI) begin
            lo_latch_q <= cnt[DIG_W-1:0];
        end
    end

    // Field split of mode registers
    always_comb begin
        clk_sel   = clkmode_q[SEL_W-1:0];
        reload_en = clkmode_q[3];
        style     = out_style_e'(outmode_q[1:0]);
        short_en  = outmode_q[2];
        irq_mask  = outmode_q[3];
    end

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            ADDR_CLKMODE: bus_rdata = clkmode_q;
            ADDR_OUTMODE: bus_rdata = outmode_q;
            ADDR_DATA_LO: bus_rdata = lo_latch_q;
            ADDR_DATA_HI: bus_rdata = cnt[CNT_W-1:DIG_W];
            ADDR_CTRL:    bus_rdata = {{(DIG_W-2){1'b0}}, flag, run};
            default:      bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/reload_pwm_timer.sv
// Top: eight-bit reload timer with toggle/PWM output and a masked overflow
// request, reached over a 4-bit digit bus. Assumes synchronous active-low reset.
module reload_pwm_timer #(
    parameter int DIG_W      = 4,
    parameter int SEL_W      = 3,
    parameter int PRESC_W    = 11,
    parameter int SHORT_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DIG_W-1:0] bus_wdata,
    output logic [DIG_W-1:0] bus_rdata,
    output logic             tmr_out,
    output logic             irq
);
    import rpt_pkg::*;

    localparam int CNT_W = 2 * DIG_W;

    logic [SEL_W-1:0] clk_sel;
    logic             reload_en;
    out_style_e       style;
    logic             short_en;
    logic             irq_mask;
    logic [CNT_W-1:0] wreg;
    logic             run;
    logic             start;
    logic             flag;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] thr;
    logic             ovf;
    logic             pwm_en;

    // PWM style decode and masked request
    always_comb begin
        pwm_en = (style == OUT_PWM);
        irq    = flag && irq_mask;
    end

    rpt_regs #(.CNT_W(CNT_W), .DIG_W(DIG_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .ovf(ovf), .clk_sel(clk_sel), .reload_en(reload_en),
        .style(style), .short_en(short_en), .irq_mask(irq_mask), .wreg(wreg),
        .run(run), .start(start), .flag(flag)
    );

    rpt_prescaler #(.PRESC_W(PRESC_W), .SEL_W(SEL_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(clk_sel), .tick(tick)
    );

    rpt_counter #(.CNT_W(CNT_W), .SHORT_LOG2(SHORT_LOG2)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .reload_en(reload_en), .pwm_en(pwm_en), .short_en(short_en),
        .wreg(wreg), .cnt(cnt), .thr(thr), .ovf(ovf)
    );

    rpt_outgen #(.CNT_W(CNT_W), .SHORT_LOG2(SHORT_LOG2)) u_out (
        .clk(clk), .rst_n(rst_n), .style(style), .short_en(short_en),
        .cnt(cnt), .thr(thr), .ovf(ovf), .start(start), .pin(tmr_out)
    );

endmodule

// File: rtl/rpt_checker.sv
// Checker: temporal properties of the reload PWM timer, bound to the top.
module rpt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       bus_addr,
    input logic             bus_wr,
    input logic [3:0]       bus_wdata,
    input logic             tmr_out,
    input logic             ovf,
    input logic             start,
    input logic             run,
    input logic             reload_en,
    input logic             pwm_en,
    input logic [1:0]       style,
    input logic             flag,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] thr,
    input logic [CNT_W-1:0] wreg
);
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !reload_en && !pwm_en) |=> (cnt == '0));  // R4
    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && reload_en && !pwm_en) |=> (cnt == $past(wreg)));  // R5
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(cnt));  // R3
    AST_FLAG_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag);  // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(bus_wr && bus_addr == 3'd4 && bus_wdata[1])) |=> flag);  // R8
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && style == 2'b01 && !bus_wr) |=> (tmr_out != $past(tmr_out)));  // R9
    AST_THR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf && !start) |=> $stable(thr));  // R12
    AST_PWM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && pwm_en) |=> (cnt == '0));  // R10
endmodule

bind reload_pwm_timer rpt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .tmr_out(tmr_out), .ovf(ovf), .start(start),
    .run(run), .reload_en(reload_en), .pwm_en(pwm_en), .style(style),
    .flag(flag), .cnt(cnt), .thr(thr), .wreg(wreg)
);

// File: tb/reload_pwm_timer_test.sv
`timescale 1ns/1ps
module reload_pwm_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       tmr_out;
    logic       irq;

    int checks = 0;
    int errors = 0;

    reload_pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_out(tmr_out), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // All bus tasks start and end at a negative edge
    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [3:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_count(output logic [7:0] v);
        logic [3:0] hi, lo;
        rd(3'd3, hi);
        rd(3'd2, lo);
        v = {hi, lo};
    endtask

    task automatic set_wreg(input logic [7:0] v);
        wr(3'd2, v[3:0]);
        wr(3'd3, v[7:4]);
    endtask

    // Start, then stop so that the stop lands on the s-th edge after start
    task automatic run_window(input int s);
        wr(3'd4, 4'd1);
        repeat (s - 1) @(negedge clk);
        wr(3'd4, 4'd0);
    endtask

    // Reference model for free-running/reload counting over t ticks
    task automatic model(input logic [7:0] w, input bit rl, input int t,
                         output logic [7:0] c, output int novf);
        c = w; novf = 0;
        for (int i = 0; i < t; i++) begin
            if (c == 8'hFF) begin c = rl ? w : 8'h00; novf++; end
            else c = c + 8'd1;
        end
    endtask

    task automatic t_reset();
        logic [3:0] d;
        logic [7:0] v;
        check("R1 tmr_out", tmr_out, 0);
        check("R1 irq", irq, 0);
        rd(3'd4, d); check("R1 ctrl", d, 0);
        rd(3'd0, d); check("R1 clkmode", d, 0);
        rd(3'd1, d); check("R1 outmode", d, 0);
        read_count(v); check("R1 count", v, 0);
    endtask

    task automatic t_free();
        logic [7:0] v, e; logic [3:0] d; int n;
        wr(3'd0, 4'h0); wr(3'd1, 4'h0);
        set_wreg(8'hF0);
        read_count(v); check("R6 count untouched", v, 0);
        run_window(40);
        model(8'hF0, 0, 20, e, n);
        read_count(v); check("R4 free wrap count", v, e);
        rd(3'd4, d); check("R8 flag set", d, 4'b0010);
        check("R8 irq masked", irq, 0);
        wr(3'd1, 4'h8);
        check("R8 irq unmasked", irq, 1);
        wr(3'd4, 4'h2);
        rd(3'd4, d); check("R8 flag cleared", d, 0);
        check("R8 irq after clear", irq, 0);
        wr(3'd1, 4'h0);
    endtask

    task automatic t_reload();
        logic [7:0] v, e; int n;
        wr(3'd0, 4'h8);
        set_wreg(8'hFC);
        run_window(20);
        model(8'hFC, 1, 10, e, n);
        read_count(v); check("R5 reload count", v, e);
        check("R5 reload overflow count", n, 2);
        wr(3'd4, 4'h2);
    endtask

    task automatic t_taps();
        logic [7:0] v, e; int n;
        wr(3'd0, 4'h2);
        set_wreg(8'h10);
        run_window(44);
        model(8'h10, 0, 5, e, n);
        read_count(v); check("R2 divide by 8", v, e);
        wr(3'd0, 4'h5);
        run_window(1100);
        model(8'h10, 0, 2, e, n);
        read_count(v); check("R2 divide by 512", v, e);
    endtask

    task automatic t_latch();
        logic [3:0] d; logic [7:0] v;
        rd(3'd3, d); check("R7 upper digit", d, 4'h1);
        wr(3'd0, 4'h0);
        set_wreg(8'h37);
        run_window(4);
        rd(3'd2, d); check("R7 captured lower digit kept", d, 4'h2);
        read_count(v); check("R7 coherent pair", v, 8'h39);
    endtask

    task automatic t_toggle();
        logic [7:0] v;
        wr(3'd0, 4'h0); wr(3'd1, 4'h1);
        set_wreg(8'hFE);
        run_window(4);
        check("R9 toggle after one overflow", tmr_out, 1);
        wr(3'd4, 4'h1);
        check("R3 start clears toggle", tmr_out, 0);
        wr(3'd4, 4'h0);
        run_window(514);
        check("R9 toggle after one more overflow", tmr_out, 1);
        read_count(v); check("R3 start reloads write register", v, 8'hFF);
        wr(3'd1, 4'h0);
        check("R9 low style", tmr_out, 0);
        wr(3'd4, 4'h2);
    endtask

    task automatic t_pwm(input bit short_mode, input int n_edges, input string req);
        logic [7:0] c, th, wm; int top; bit exp;
        wr(3'd0, 4'h8);
        wr(3'd1, short_mode ? 4'h6 : 4'h2);
        set_wreg(8'h40);
        wm = 8'h40;
        wr(3'd4, 4'h1);
        c = 0; th = wm;
        top = short_mode ? 63 : 255;
        check({req, " start"}, tmr_out, 1);
        for (int k = 1; k <= n_edges; k++) begin
            if (k == 150) begin bus_addr = 3'd2; bus_wdata = 4'h0; bus_wr = 1'b1; end
            else if (k == 151) begin bus_addr = 3'd3; bus_wdata = 4'hC; bus_wr = 1'b1; end
            else bus_wr = 1'b0;
            @(negedge clk);
            if (k % 2 == 0) begin
                if (int'(c) == top) begin c = 0; th = wm; end
                else c = c + 8'd1;
            end
            if (k == 151) wm = 8'hC0;
            exp = short_mode ? (c < (th >> 2)) : (c < th);
            check({req, " R12 waveform"}, tmr_out, exp);
        end
        bus_wr = 1'b0;
        wr(3'd4, 4'h2);
        wr(3'd1, 4'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_free();
        t_reload();
        t_taps();
        t_latch();
        t_toggle();
        t_pwm(0, 1200, "R10");
        t_pwm(1, 400, "R11");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule